// File: doc/BRIEF.md
# Retrying Reset Sequencer for a Multi-Domain Device

This controller owns the active-low reset pin of an attached device that has several internal domains (digital core, clock synthesizer, serial link PLL). On a start request it asserts the pin through three timed low phases: initiation, a wait for the clocks to settle, and a final hold. It then releases the pin and waits for the device's internal synthesizer timer and for the serial link to settle. At the end of the last wait it reads the device's status word and decides whether the bring-up worked.

A failed attempt re-runs the whole schedule automatically, up to a bounded number of attempts. After that the block reports failure. Every wait is a parameter in microseconds, scaled by a clock-cycles-per-microsecond parameter, and one down-counter times all phases. The status word comes from another domain and passes through a two-flop synchronizer before the check.

Top module: `rstseq_top`

## Requirements
- R1: After reset the pin `dev_rst_no` is low (device held in reset), `busy_o`, `done_o`, `pass_o` and `fail_o` are low, and `attempt_o` is 0. The pin stays low until a sequence releases it.
- R2: A start request while idle begins attempt 1. One cycle later `busy_o` is high, `dev_rst_no` is low, `attempt_o` is 1, and `pass_o` and `fail_o` are cleared.
- R3: In every attempt the pin is held low for exactly (T_INIT_US + T_CLKS_US + T_HOLD_US) * CYC_PER_US cycles and is then driven high.
- R4: After the pin is released the block waits (T_SYNTH_US + T_SERIAL_US) * CYC_PER_US cycles and then decides. A final decision raises `done_o` for exactly one cycle and drops `busy_o` in that same cycle.
- R5: An attempt passes only if status bit 0 (reset timer expired) is 1, status bit 1 (serial PLL timer expired) is 1, and status bits 2 to 5 (the four monitored out-of-lock flags) are all 0.
- R6: Status bit 6 (the late-locking out-of-lock flag) has no effect on the result.
- R7: A failing attempt below MAX_TRIES starts the next attempt at once. `attempt_o` increments, and the pin goes low again and repeats the full schedule.
- R8: When attempt MAX_TRIES fails, `fail_o` is set together with `done_o`, and the pin stays released high.
- R9: A start request while `busy_o` is high is ignored. It does not change the attempt number or the time of the decision.
- R10: Status is sampled only through the two-flop synchronizer, at the end of the final wait. Values outside that sampling point, including a change in the last cycle before the decision edge, do not affect the result.
- R11: `pass_o` and `fail_o` are never both high. The result holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| start_i | input | 1 | Request to run the reset sequence |
| status_i | input | 7 | Device status word, asynchronous, layout as in R5/R6 |
| dev_rst_no | output | 1 | Active-low reset pin of the device |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the final decision is made |
| pass_o | output | 1 | Last sequence succeeded |
| fail_o | output | 1 | Last sequence exhausted its attempts |
| attempt_o | output | $clog2(MAX_TRIES+1) | Current or final attempt number |

## Verification
The bench measures every low pulse of the pin and the cycle of each decision against the schedule length. A design that loaded the counter one short, or that skipped a phase on a retry, shows up as a wrong pulse width or an early `done_o`. It drives each pass condition bad on its own, and also the excluded late-lock flag. A check that used the wrong bit or tested that flag would turn a pass into a fail. It recovers a failing device at attempt 2, pulses start while busy, and changes the status both in the middle of the wait and in the very last cycle before the decision. A block that sampled early, lacked a synchronizer or restarted on a second start would then report the wrong result, attempt number or timing.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    // Width and bit map of the device status word
    localparam int unsigned STAT_W       = 7;
    localparam int unsigned BIT_RST_TMR  = 0;  // reset timer expired
    localparam int unsigned BIT_SER_PLL  = 1;  // serial PLL timer expired
    localparam int unsigned BIT_OOL_LO   = 2;  // first monitored out-of-lock flag
    localparam int unsigned BIT_OOL_HI   = 5;  // last monitored out-of-lock flag
    localparam int unsigned BIT_LATE_OOL = 6;  // late-locking flag, not judged

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_INIT   = 3'd1,
        PH_CLKS   = 3'd2,
        PH_HOLD   = 3'd3,
        PH_SYNTH  = 3'd4,
        PH_SERIAL = 3'd5
    } phase_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_d, meta_q, stab_d, stab_q;

    always_comb begin
        meta_d = d_i;
        stab_d = meta_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rstseq_judge.sv
module rstseq_judge
    import rstseq_pkg::*;
(
    input  logic [STAT_W-1:0] stat_i,
    output logic              ok_o
);
    logic unused_late_ool;
    assign unused_late_ool = stat_i[BIT_LATE_OOL];

    always_comb begin
        ok_o = stat_i[BIT_RST_TMR] & stat_i[BIT_SER_PLL]
             & ~(|stat_i[BIT_OOL_HI:BIT_OOL_LO]);
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 250,
    parameter int unsigned T_INIT_US   = 1000,
    parameter int unsigned T_CLKS_US   = 1000,
    parameter int unsigned T_HOLD_US   = 2000,
    parameter int unsigned T_SYNTH_US  = 15000,
    parameter int unsigned T_SERIAL_US = 1000,
    parameter int unsigned MAX_TRIES   = 3,
    localparam int unsigned AW = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [STAT_W-1:0] status_i,
    output logic              dev_rst_no,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic [AW-1:0]     attempt_o
);
    localparam int unsigned LEN_INIT   = T_INIT_US   * CYC_PER_US;
    localparam int unsigned LEN_CLKS   = T_CLKS_US   * CYC_PER_US;
    localparam int unsigned LEN_HOLD   = T_HOLD_US   * CYC_PER_US;
    localparam int unsigned LEN_SYNTH  = T_SYNTH_US  * CYC_PER_US;
    localparam int unsigned LEN_SERIAL = T_SERIAL_US * CYC_PER_US;
    localparam int unsigned MAX_A = (LEN_INIT > LEN_CLKS) ? LEN_INIT : LEN_CLKS;
    localparam int unsigned MAX_B = (LEN_HOLD > LEN_SYNTH) ? LEN_HOLD : LEN_SYNTH;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MAX_LEN = (MAX_C > LEN_SERIAL) ? MAX_C : LEN_SERIAL;
    localparam int unsigned CW = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

    typedef struct packed {
        phase_e        ph;
        logic          pin_n;
        logic          busy;
        logic          done;
        logic          pass;
        logic          fail;
        logic [AW-1:0] att;
    } seq_t;

    seq_t st_d, st_q;

    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              tmr_exp;
    logic [STAT_W-1:0] stat_sync;
    logic              stat_ok;

    function automatic logic [CW-1:0] phase_len(phase_e p);
        case (p)
            PH_INIT:   phase_len = CW'(LEN_INIT - 1);
            PH_CLKS:   phase_len = CW'(LEN_CLKS - 1);
            PH_HOLD:   phase_len = CW'(LEN_HOLD - 1);
            PH_SYNTH:  phase_len = CW'(LEN_SYNTH - 1);
            PH_SERIAL: phase_len = CW'(LEN_SERIAL - 1);
            default:   phase_len = '0;
        endcase
    endfunction

    rstseq_sync #(.W(STAT_W)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (status_i),
        .q_o    (stat_sync)
    );

    rstseq_judge u_judge (
        .stat_i (stat_sync),
        .ok_o   (stat_ok)
    );

    rstseq_timer #(.CW(CW)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph    = PH_INIT;
                    st_d.pin_n = 1'b0;
                    st_d.busy  = 1'b1;
                    st_d.pass  = 1'b0;
                    st_d.fail  = 1'b0;
                    st_d.att   = AW'(1);
                end
            end
            PH_INIT: if (tmr_exp) st_d.ph = PH_CLKS;
            PH_CLKS: if (tmr_exp) st_d.ph = PH_HOLD;
            PH_HOLD: begin
                if (tmr_exp) begin
                    st_d.ph    = PH_SYNTH;
                    st_d.pin_n = 1'b1;
                end
            end
            PH_SYNTH: if (tmr_exp) st_d.ph = PH_SERIAL;
            PH_SERIAL: begin
                if (tmr_exp) begin
                    if (stat_ok) begin
                        st_d.ph   = PH_IDLE;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.pass = 1'b1;
                    end else if (st_q.att < AW'(MAX_TRIES)) begin
                        st_d.ph    = PH_INIT;
                        st_d.pin_n = 1'b0;
                        st_d.att   = st_q.att + AW'(1);
                    end else begin
                        st_d.ph   = PH_IDLE;
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.fail = 1'b1;
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
        tmr_load = (st_d.ph != st_q.ph);
        tmr_val  = phase_len(st_d.ph);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ph: PH_IDLE, pin_n: 1'b0, busy: 1'b0, done: 1'b0,
                      pass: 1'b0, fail: 1'b0, att: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_rst_no = st_q.pin_n;
    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign pass_o     = st_q.pass;
    assign fail_o     = st_q.fail;
    assign attempt_o  = st_q.att;

    AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pass_o && fail_o)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R4
    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R4
    AST_DONE_AT_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(tmr_exp)); // R4
    AST_RELEASE_AT_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dev_rst_no) |-> $past(tmr_exp)); // R3
    AST_ATTEMPT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        attempt_o <= AW'(MAX_TRIES)); // R7
    AST_RETRY_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && attempt_o != $past(attempt_o)) |-> !dev_rst_no); // R7
    AST_FAIL_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fail_o) |-> dev_rst_no); // R8
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !tmr_exp) |=> attempt_o == $past(attempt_o)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o))); // R11
endmodule

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;
    localparam int CYC = 2;
    localparam int LOW_LEN = (3 + 2 + 4) * CYC;     // 18
    localparam int ATT_LEN = LOW_LEN + (5 + 3) * CYC; // 34
    localparam logic [6:0] GOOD = 7'b000_0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [6:0] status = GOOD;
    logic dev_rst_n, busy, done, pass, fail;
    logic [1:0] attempt;

    always #2 clk = ~clk;

    rstseq_top #(
        .CYC_PER_US(CYC), .T_INIT_US(3), .T_CLKS_US(2), .T_HOLD_US(4),
        .T_SYNTH_US(5), .T_SERIAL_US(3), .MAX_TRIES(3)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .status_i(status),
        .dev_rst_no(dev_rst_n), .busy_o(busy), .done_o(done),
        .pass_o(pass), .fail_o(fail), .attempt_o(attempt)
    );

    typedef struct {
        bit     pass;
        int     tries;
        longint dcyc;
        string  tag;
    } exp_t;
    exp_t sb_q[$];

    int nchk = 0;
    int nfail = 0;
    longint cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard comparison and reset-pulse measurement
    bit prev_pin = 0;
    bit armed = 0;
    int lowcnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R4", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(pass == e.pass, e.tag, "pass_o", pass, e.pass);
                    chk(fail == !e.pass, e.tag, "fail_o", fail, !e.pass);
                    chk(attempt == 2'(e.tries), e.tag, "attempt_o", attempt, e.tries);
                    chk(cyc == e.dcyc, "R4", "decision cycle", cyc, e.dcyc);
                end
            end
            if (prev_pin && !dev_rst_n) begin
                armed = 1;
                lowcnt = 1;
            end else if (!dev_rst_n && armed) begin
                lowcnt++;
            end else if (dev_rst_n && !prev_pin && armed) begin
                chk(lowcnt == LOW_LEN, "R3", "low pulse width", lowcnt, LOW_LEN);
                armed = 0;
            end
            prev_pin = dev_rst_n;
        end
    end

    // Driver: start a sequence and push the expected result
    task automatic start_seq(input bit exp_pass, input int tries, input string tag,
                             output longint s);
        @(negedge clk);
        start = 1'b1;
        s = cyc;
        sb_q.push_back('{exp_pass, tries, s + 1 + tries * ATT_LEN, tag});
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        chk(dev_rst_n == 1'b0, "R2", "pin after start", dev_rst_n, 0);
        chk(attempt == 2'd1, "R2", "attempt after start", attempt, 1);
        chk(!pass && !fail, "R2", "result cleared", {pass, fail}, 0);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        summary();
    end

    initial begin
        longint s;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dev_rst_n == 0, "R1", "pin in reset", dev_rst_n, 0);
        chk(busy == 0, "R1", "busy in reset", busy, 0);
        chk(done == 0, "R1", "done in reset", done, 0);
        chk(pass == 0 && fail == 0, "R1", "result in reset", {pass, fail}, 0);
        chk(attempt == 0, "R1", "attempt in reset", attempt, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(dev_rst_n == 0, "R1", "pin held before first start", dev_rst_n, 0);

        // R5: good status passes at first attempt
        status = GOOD;
        start_seq(1, 1, "R5", s);
        drain();
        chk(dev_rst_n == 1, "R3", "pin released after pass", dev_rst_n, 1);
        // R11: result held while idle
        repeat (6) @(negedge clk);
        chk(pass == 1 && fail == 0, "R11", "result held", {pass, fail}, 2);

        // R6: excluded flag has no effect
        status = GOOD | 7'b100_0000;
        start_seq(1, 1, "R6", s);
        drain();

        // R7/R8: monitored out-of-lock flag (bit 4) fails every attempt
        status = GOOD | 7'b001_0000;
        start_seq(0, 3, "R8", s);
        drain();
        chk(dev_rst_n == 1, "R8", "pin high after fail", dev_rst_n, 1);

        // R5: reset timer flag clear
        status = 7'b000_0010;
        start_seq(0, 3, "R5", s);
        drain();

        // R5: serial PLL flag clear
        status = 7'b000_0001;
        start_seq(0, 3, "R5", s);
        drain();

        // R7: device recovers in attempt 2
        status = GOOD | 7'b000_0100;
        start_seq(1, 2, "R7", s);
        while (attempt != 2'd2) @(negedge clk);
        chk(dev_rst_n == 0, "R7", "pin low on retry", dev_rst_n, 0);
        status = GOOD;
        drain();

        // R9: start while busy ignored
        status = GOOD;
        start_seq(1, 1, "R9", s);
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(attempt == 2'd1, "R9", "attempt after busy start", attempt, 1);
        chk(busy == 1'b1, "R9", "still busy", busy, 1);
        drain();

        // R10: status glitch in mid-wait ignored
        start_seq(1, 1, "R10", s);
        while (cyc < s + 22) @(negedge clk);
        status = GOOD | 7'b010_0000;
        while (cyc < s + 26) @(negedge clk);
        status = GOOD;
        drain();

        // R10: change in the last cycle before the decision is not seen
        start_seq(1, 1, "R10", s);
        while (cyc < s + ATT_LEN) @(negedge clk);
        status = GOOD | 7'b000_1000;
        drain();
        status = GOOD;

        summary();
    end
endmodule